// File: doc/BRIEF.md
# POST Code Seven-Segment Display Driver

This block watches the host's I/O write strobe. When a write targets the diagnostic port address 0x80, it keeps the data byte. It shows that byte as two hexadecimal characters on a two-digit seven-segment display. The two digits share one segment bus and have one select line each. The block drives the high and low digits in turn at a scan rate set by parameters. When a mode input is set, the display shows an 8-bit temperature input instead of the POST byte.

The display runs when either of two conditions holds. One is a strap input that is sampled once, on the first clock edge after reset is released. The other is a live enable bit from a configuration register. When neither is set, the outputs stay dark and the kept byte is cleared. All outputs are registered. Each time the active digit changes, the display goes blank for one clock so that the previous character does not bleed onto the next digit.

Top module: `post_code_display`

## Requirements
- R1: While enabled, a cycle with `io_wr_i`=1 and `io_addr_i`=0x0080 loads `io_data_i` into the kept byte on that clock edge. The kept byte then appears on the display within two further edges.
- R2: The kept byte is left unchanged by a write to any other address, including one that differs from 0x0080 only in its upper bits, and by a read strobe (`io_rd_i`) to 0x0080.
- R3: Segments are active high, with `seg_o` bits [6:0] = g,f,e,d,c,b,a. The nibble codes are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 b:7C C:39 d:5E E:79 F:71. The letters b and d are lowercase.
- R4: `dig_o[1]` selects the high nibble and `dig_o[0]` selects the low nibble. Each digit is shown for SCAN_DIV-1 consecutive cycles, where SCAN_DIV = CLK_HZ/SCAN_HZ. The two digits alternate, so the full scan period is 2*SCAN_DIV cycles.
- R5: Between the two digits there is exactly one cycle in which both `seg_o` and `dig_o` are zero.
- R6: When `temp_mode_i`=1, the display shows `temp_i` in place of the kept byte. Writes to 0x0080 are still captured during this mode.
- R7: The block is enabled when `reg_en_i`=1, or when `strap_en_i` was 1 at the first clock edge after reset. Later changes on `strap_en_i` have no effect.
- R8: While disabled, `seg_o` and `dig_o` are 0 and the kept byte is cleared to 0x00. Writes are not captured while disabled.
- R9: During reset, and immediately after it with no enable, `seg_o` and `dig_o` are 0.
- R10: At most one bit of `dig_o` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_en_i | input | 1 | Enable strap, sampled once after reset |
| reg_en_i | input | 1 | Enable bit from a configuration register |
| temp_mode_i | input | 1 | 1 = show the temperature input |
| temp_i | input | 8 | Temperature byte |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_rd_i | input | 1 | I/O read strobe |
| io_addr_i | input | ADDR_W | I/O address |
| io_data_i | input | 8 | I/O write data |
| seg_o | output | 7 | Segment bus, g..a, active high |
| dig_o | output | 2 | Digit selects: [1] high nibble, [1:0] bit 0 low nibble |

## Verification
The assertions assume that the I/O strobe, address and data are synchronous to `clk_i` and valid at the sampling edge. They also assume that the enable inputs change only between edges. The capture property relates a qualified write to the kept byte one edge later, so it depends on this. The bench drives every input on the falling edge and holds each strobe for exactly one cycle, so every transaction is seen exactly once. The bench lowers the scan divider to 16 so that the period and blanking checks fit in a short run.

// File: rtl/post_disp_pkg.sv
package post_disp_pkg;
  typedef logic [3:0] nib_t;
  typedef logic [6:0] seg_t;

  // gfedcba, active high; b and d lowercase
  function automatic seg_t hex_to_seg(input nib_t n);
    case (n)
      4'h0: return 7'h3F;
      4'h1: return 7'h06;
      4'h2: return 7'h5B;
      4'h3: return 7'h4F;
      4'h4: return 7'h66;
      4'h5: return 7'h6D;
      4'h6: return 7'h7D;
      4'h7: return 7'h07;
      4'h8: return 7'h7F;
      4'h9: return 7'h6F;
      4'hA: return 7'h77;
      4'hB: return 7'h7C;
      4'hC: return 7'h39;
      4'hD: return 7'h5E;
      4'hE: return 7'h79;
      default: return 7'h71;
    endcase
  endfunction
endpackage

// File: rtl/post_disp_snoop.sv
module post_disp_snoop #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] POST_ADDR = 'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [7:0]        io_data_i,
  output logic [7:0]        held_o
);
  logic hit;
  assign hit = io_wr_i && (io_addr_i == POST_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held_o <= '0;
    else if (!en_i) held_o <= '0;
    else if (hit)  held_o <= io_data_i;
  end
endmodule

// File: rtl/post_disp_scan.sv
module post_disp_scan #(
  parameter int SCAN_DIV = 48000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic phase_o,  // 0: high digit, 1: low digit
  output logic swap_o    // last cycle of a digit slot
);
  localparam int CNT_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SCAN_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign swap_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_o <= ~phase_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/post_disp_seg7.sv
module post_disp_seg7
  import post_disp_pkg::*;
(
  input  nib_t nib_i,
  output seg_t seg_o
);
  assign seg_o = hex_to_seg(nib_i);
endmodule

// File: rtl/post_code_display.sv
module post_code_display
  import post_disp_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] POST_ADDR = 'h80,
  parameter int                CLK_HZ    = 48_000_000,
  parameter int                SCAN_HZ   = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_en_i,
  input  logic              reg_en_i,
  input  logic              temp_mode_i,
  input  logic [7:0]        temp_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [7:0]        io_data_i,
  output logic [6:0]        seg_o,
  output logic [1:0]        dig_o
);
  localparam int SCAN_DIV = CLK_HZ / SCAN_HZ;
  localparam int N_DIG    = 2;

  logic       strap_q, strap_taken_q, en;
  logic [7:0] held_q, disp_byte;
  logic       phase, swap;
  logic       rd_unused;

  assign rd_unused = io_rd_i;  // reads never alter state

  // strap sampled on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q       <= 1'b0;
      strap_taken_q <= 1'b0;
    end else if (!strap_taken_q) begin
      strap_q       <= strap_en_i;
      strap_taken_q <= 1'b1;
    end
  end

  assign en = strap_q | reg_en_i;

  post_disp_snoop #(.ADDR_W(ADDR_W), .POST_ADDR(POST_ADDR)) u_snoop (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .io_wr_i   (io_wr_i),
    .io_addr_i (io_addr_i),
    .io_data_i (io_data_i),
    .held_o    (held_q)
  );

  post_disp_scan #(.SCAN_DIV(SCAN_DIV)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .phase_o (phase),
    .swap_o  (swap)
  );

  assign disp_byte = temp_mode_i ? temp_i : held_q;

  seg_t enc [N_DIG];
  for (genvar g = 0; g < N_DIG; g++) begin : g_dig
    post_disp_seg7 u_enc (
      .nib_i (disp_byte[4*g +: 4]),
      .seg_o (enc[g])
    );
  end

  logic sel;
  assign sel = ~phase;  // phase 0 -> digit 1 (high nibble)

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_o <= '0;
      dig_o <= '0;
    end else if (!en || swap) begin
      seg_o <= '0;
      dig_o <= '0;
    end else begin
      seg_o <= enc[sel];
      dig_o <= sel ? 2'b10 : 2'b01;
    end
  end
endmodule

// File: rtl/post_disp_checker.sv
module post_disp_checker #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] POST_ADDR = 'h80
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              io_wr_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic [7:0]        io_data_i,
  input logic [7:0]        held_i,
  input logic [6:0]        seg_i,
  input logic [1:0]        dig_i
);
  a_r1_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && io_wr_i && io_addr_i == POST_ADDR) |=> held_i == $past(io_data_i));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(io_wr_i && io_addr_i == POST_ADDR)) |=> $stable(held_i));

  a_r5_swap_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_i != 2'b00) |=> (dig_i == 2'b00 || dig_i == $past(dig_i)));

  a_r5_dark_segs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_i == 2'b00) |-> (seg_i == 7'h00));

  a_r8_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (seg_i == 7'h00 && dig_i == 2'b00 && held_i == 8'h00));

  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dig_i));
endmodule

bind post_code_display post_disp_checker #(.ADDR_W(ADDR_W), .POST_ADDR(POST_ADDR)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en),
  .io_wr_i   (io_wr_i),
  .io_addr_i (io_addr_i),
  .io_data_i (io_data_i),
  .held_i    (held_q),
  .seg_i     (seg_o),
  .dig_i     (dig_o)
);

// File: tb/tb_post_code_display.sv
module tb_post_code_display;
  localparam int DIV = 16;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        strap_en_i = 1'b0, reg_en_i = 1'b0, temp_mode_i = 1'b0;
  logic [7:0]  temp_i = '0, io_data_i = '0;
  logic        io_wr_i = 1'b0, io_rd_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic [6:0]  seg_o;
  logic [1:0]  dig_o;

  int n_run = 0, n_fail = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;

  post_code_display #(.ADDR_W(16), .POST_ADDR(16'h0080), .CLK_HZ(16000), .SCAN_HZ(1000)) dut (.*);

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h0080, 8'hA5, 8'hA5},  // R1
    '{1'b1, 1'b0, 16'h0081, 8'h11, 8'hA5},  // R2
    '{1'b0, 1'b1, 16'h0080, 8'h22, 8'hA5},  // R2 read
    '{1'b1, 1'b0, 16'h0080, 8'hBD, 8'hBD},  // R3 b,d
    '{1'b1, 1'b0, 16'h0180, 8'h77, 8'hBD},  // R2 upper bits
    '{1'b1, 1'b0, 16'h0080, 8'h00, 8'h00},
    '{1'b1, 1'b0, 16'h007F, 8'h99, 8'h00},  // R2
    '{1'b1, 1'b0, 16'h0080, 8'hF1, 8'hF1},
    '{1'b1, 1'b0, 16'h0080, 8'h3C, 8'h3C},
    '{1'b1, 1'b0, 16'h0080, 8'h86, 8'h86}
  };

  function automatic logic [6:0] seg_of(input logic [3:0] n);
    case (n)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic wait_dig(input logic [1:0] d);
    for (int i = 0; i < 4 * DIV; i++) begin
      if (dig_o == d) return;
      @(negedge clk_i);
    end
    check(1'b0, "R4 digit never active", int'(dig_o), int'(d));
  endtask

  task automatic show_check(input logic [7:0] b, input string req);
    repeat (3) @(negedge clk_i);
    wait_dig(2'b10);
    check(seg_o == seg_of(b[7:4]), {req, " high digit"}, int'(seg_o), int'(seg_of(b[7:4])));
    wait_dig(2'b01);
    check(seg_o == seg_of(b[3:0]), {req, " low digit"}, int'(seg_o), int'(seg_of(b[3:0])));
  endtask

  task automatic io_cycle(input logic wr, input logic rd, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    io_wr_i = wr; io_rd_i = rd; io_addr_i = a; io_data_i = d;
    @(negedge clk_i);
    io_wr_i = 1'b0; io_rd_i = 1'b0;
  endtask

  task automatic dark_check(input string req, input int n);
    bit dark = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (seg_o != 0 || dig_o != 0) dark = 1'b0;
    end
    check(dark, req, int'({dig_o, seg_o}), 0);
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk_i);
    rst_ni = 1'b0; strap_en_i = strap;
    repeat (2) @(negedge clk_i);
    check(seg_o == 0 && dig_o == 0, "R9 reset outputs", int'({dig_o, seg_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    do_reset(1'b0);
    dark_check("R9 idle after reset, not enabled", 2 * DIV);

    // R8: writes ignored while disabled
    io_cycle(1'b1, 1'b0, 16'h0080, 8'h5A);
    reg_en_i = 1'b1;
    show_check(8'h00, "R8 write while disabled ignored");

    // R1/R2/R3 vector table
    for (int v = 0; v < NV; v++) begin
      io_cycle(VECS[v].wr, VECS[v].rd, VECS[v].addr, VECS[v].data);
      show_check(VECS[v].exp, $sformatf("R1/R2/R3 vec%0d", v));
    end

    // R3 every nibble
    for (int k = 0; k < 16; k += 2) begin
      io_cycle(1'b1, 1'b0, 16'h0080, {4'(k), 4'(k + 1)});
      show_check({4'(k), 4'(k + 1)}, "R3 encoding");
    end

    // R4/R5 timing
    begin
      int len = 0;
      io_cycle(1'b1, 1'b0, 16'h0080, 8'h42);
      wait_dig(2'b01);
      wait_dig(2'b10);
      while (dig_o == 2'b10 && len < 4 * DIV) begin
        len++;
        @(negedge clk_i);
      end
      check(len == DIV - 1, "R4 high slot length", len, DIV - 1);
      check(dig_o == 2'b00 && seg_o == 7'h00, "R5 blank cycle", int'({dig_o, seg_o}), 0);
      @(negedge clk_i);
      check(dig_o == 2'b01, "R4 low digit follows blank", int'(dig_o), 1);
      check(seg_o == seg_of(4'h2), "R4 low digit value", int'(seg_o), int'(seg_of(4'h2)));
      len = 0;
      while (dig_o == 2'b01 && len < 4 * DIV) begin
        len++;
        @(negedge clk_i);
      end
      check(len == DIV - 1, "R4 low slot length", len, DIV - 1);
      check(dig_o == 2'b00 && seg_o == 7'h00, "R5 blank before high", int'({dig_o, seg_o}), 0);
      @(negedge clk_i);
      check(dig_o == 2'b10, "R10 high after blank", int'(dig_o), 2);
    end

    // R6 temperature mode
    temp_mode_i = 1'b1; temp_i = 8'h4E;
    show_check(8'h4E, "R6 temperature shown");
    io_cycle(1'b1, 1'b0, 16'h0080, 8'h12);
    show_check(8'h4E, "R6 temp stays during write");
    temp_mode_i = 1'b0;
    show_check(8'h12, "R6 write captured in temp mode");

    // R8 disable clears
    @(negedge clk_i); reg_en_i = 1'b0;
    dark_check("R8 outputs dark while disabled", 2 * DIV);
    reg_en_i = 1'b1;
    show_check(8'h00, "R8 kept byte cleared");

    // R7 strap enable, later strap changes ignored
    reg_en_i = 1'b0;
    do_reset(1'b1);
    strap_en_i = 1'b0;
    io_cycle(1'b1, 1'b0, 16'h0080, 8'hC7);
    show_check(8'hC7, "R7 strap enables after strap drops");

    // R7 strap low: stays dark
    do_reset(1'b0);
    strap_en_i = 1'b1;
    dark_check("R7 strap sampled low keeps block off", 2 * DIV);

    finish_run();
  end
endmodule